// File: doc/BRIEF.md
# Half-Rate Clock Generator with Filtered Reset Sequencer

This block runs from the oscillator clock and makes the chip's internal state clock at half the oscillator rate with an even duty cycle. One state time is two oscillator periods, which is one period of that divided clock. The same block watches the active-low external reset request and decides when the core comes out of reset.

The request goes through a two-flop synchroniser. A low level is accepted as a reset only once it has been seen for four state times in a row; shorter dips are thrown away. While the reset is accepted the core is held in reset and the block pulls the reset pad low through an open-drain enable. When the request goes high again, the divided clock is forced to a known phase and a release sequence of ten state times runs. The core is released at the end of that sequence. The `ext_rst_n` input is the level the board drives, sensed before the block's own pull-down. When power comes up the block starts in the accepted state, so the core stays in reset until the request is high. `por_n` is the block's asynchronous power-on clear.

Top module: `clkdiv_rstseq`

## Requirements
- R1: Outside the realign edge of R4, `state_clk` inverts on every rising edge of `osc_clk`. It therefore runs at half the oscillator rate with a 50% duty cycle.
- R2: A synchronised low on `ext_rst_n` that lasts fewer than 8 oscillator cycles (4 state times) has no effect on any output. Its run count clears when the level goes high.
- R3: After 8 consecutive synchronised low samples, `core_rst_n` is 0 from the next edge on. After `por_n` the block starts in this accepted state.
- R4: In the accepted state, the first synchronised high sample forces `state_clk` to 0 at that edge, and `state_clk` toggles again from the edge after.
- R5: The release sequence lasts exactly 20 oscillator cycles (10 state times). `core_rst_n` goes to 1 at the edge after its last cycle.
- R6: `rst_pull_low` is 1 exactly while the reset is accepted or the sequence is running, and 0 otherwise.
- R7: During the release sequence `ext_rst_n` is ignored, so a low on it neither shortens nor restarts the sequence.
- R8: A change on `ext_rst_n` first affects the block at the third rising edge of `osc_clk` after it is applied, which is the two-flop synchroniser latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| ext_rst_n | input | 1 | External reset request level, active low |
| state_clk | output | 1 | Divided clock, half the oscillator rate |
| core_rst_n | output | 1 | Reset to the core, active low |
| rst_pull_low | output | 1 | Open-drain enable: 1 pulls the reset pad low |

## Verification
Two events can land on the same edge. The realign of the divided clock happens on the very edge that moves the block from the accepted state into the release sequence. A fresh low request can also arrive while that sequence is still counting. The bench produces the first case every time a random low pulse long enough to be accepted ends. It produces the second by dropping the request again within the 20 cycles after a release starts. A cycle-level model of the requirements in the bench judges each edge: `state_clk` must read 0 right after the entry edge, and the sequence must still end exactly 20 cycles after it began.

// File: rtl/clkdiv_rstseq_pkg.sv
package clkdiv_rstseq_pkg;
  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_HELD = 2'd1,
    PH_SEQ  = 2'd2
  } rst_phase_t;
endpackage

// File: rtl/crs_sync.sv
module crs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n)
          if (!arst_n) chain[i] <= 1'b0;
          else         chain[i] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n)
          if (!arst_n) chain[i] <= 1'b0;
          else         chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/crs_halver.sv
module crs_halver (
  input  logic clk,
  input  logic arst_n,
  input  logic realign,
  output logic clk_div
);
  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)      clk_div <= 1'b0;
    else if (realign) clk_div <= 1'b0;
    else              clk_div <= ~clk_div;

  assert_toggle_R1: assert property (@(posedge clk) disable iff (!arst_n)
    !realign |=> clk_div != $past(clk_div));
  assert_realign_R4: assert property (@(posedge clk) disable iff (!arst_n)
    realign |=> !clk_div);
endmodule

// File: rtl/crs_sequencer.sv
module crs_sequencer
  import clkdiv_rstseq_pkg::*;
#(
  parameter int ACCEPT_ST = 4,
  parameter int SEQ_ST    = 10
) (
  input  logic clk,
  input  logic arst_n,
  input  logic req_n_s,
  output logic realign,
  output logic core_rst_n,
  output logic pull_low
);
  localparam int ACC_CYC  = 2 * ACCEPT_ST;
  localparam int SEQ_CYC  = 2 * SEQ_ST;
  localparam int MAX_CYC  = (ACC_CYC > SEQ_CYC) ? ACC_CYC : SEQ_CYC;
  localparam int CW       = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] ACC_LAST = CW'(ACC_CYC - 1);
  localparam logic [CW-1:0] SEQ_LAST = CW'(SEQ_CYC - 1);

  rst_phase_t      phase, phase_nx;
  logic [CW-1:0]   cnt, cnt_nx;

  always_comb begin
    phase_nx = phase;
    cnt_nx   = cnt;
    realign  = 1'b0;
    unique case (phase)
      PH_RUN: begin
        if (req_n_s) cnt_nx = '0;
        else if (cnt == ACC_LAST) begin
          phase_nx = PH_HELD;
          cnt_nx   = '0;
        end else cnt_nx = cnt + 1'b1;
      end
      PH_HELD: begin
        if (req_n_s) begin
          phase_nx = PH_SEQ;
          cnt_nx   = '0;
          realign  = 1'b1;
        end
      end
      PH_SEQ: begin
        if (cnt == SEQ_LAST) begin
          phase_nx = PH_RUN;
          cnt_nx   = '0;
        end else cnt_nx = cnt + 1'b1;
      end
      default: begin
        phase_nx = PH_HELD;
        cnt_nx   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      phase <= PH_HELD;
      cnt   <= '0;
    end else begin
      phase <= phase_nx;
      cnt   <= cnt_nx;
    end

  assign core_rst_n = (phase == PH_RUN);
  assign pull_low   = (phase == PH_HELD) || (phase == PH_SEQ);

  assert_accept_R3: assert property (@(posedge clk) disable iff (!arst_n)
    (phase == PH_RUN && !req_n_s && cnt == ACC_LAST) |=> !core_rst_n);
  assert_short_low_R2: assert property (@(posedge clk) disable iff (!arst_n)
    (phase == PH_RUN && cnt != ACC_LAST) |=> core_rst_n);
  assert_release_R5: assert property (@(posedge clk) disable iff (!arst_n)
    (phase == PH_SEQ && cnt == SEQ_LAST) |=> core_rst_n && !pull_low);
  assert_seq_hold_R7: assert property (@(posedge clk) disable iff (!arst_n)
    (phase == PH_SEQ && cnt != SEQ_LAST) |=> phase == PH_SEQ && cnt == $past(cnt) + 1'b1);
  assert_pull_R6: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(pull_low) |-> $past(phase) == PH_SEQ);
endmodule

// File: rtl/clkdiv_rstseq.sv
module clkdiv_rstseq #(
  parameter int ACCEPT_ST   = 4,
  parameter int SEQ_ST      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic osc_clk,
  input  logic por_n,
  input  logic ext_rst_n,
  output logic state_clk,
  output logic core_rst_n,
  output logic rst_pull_low
);
  logic req_s;
  logic realign;

  crs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(osc_clk), .arst_n(por_n), .d(ext_rst_n), .q(req_s)
  );

  crs_sequencer #(.ACCEPT_ST(ACCEPT_ST), .SEQ_ST(SEQ_ST)) u_seq (
    .clk(osc_clk), .arst_n(por_n), .req_n_s(req_s),
    .realign(realign), .core_rst_n(core_rst_n), .pull_low(rst_pull_low)
  );

  crs_halver u_div (
    .clk(osc_clk), .arst_n(por_n), .realign(realign), .clk_div(state_clk)
  );
endmodule

// File: tb/sim_clkdiv_rstseq.sv
module sim_clkdiv_rstseq;
  logic osc_clk = 1'b0;
  logic por_n = 1'b0;
  logic ext_rst_n = 1'b0;
  logic state_clk, core_rst_n, rst_pull_low;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 osc_clk = ~osc_clk;

  clkdiv_rstseq u0 (
    .osc_clk(osc_clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
    .state_clk(state_clk), .core_rst_n(core_rst_n), .rst_pull_low(rst_pull_low)
  );

  // Requirement model: 0 run, 1 accepted, 2 sequence
  int m_state = 1;
  int m_low = 0;
  int m_seq = 0;
  bit m_s1 = 0, m_s2 = 0, m_ps = 0, m_clk = 0;

  function automatic string tag_core(int st, bit ps);
    if (st == 2) return ps ? "R5" : "R7";
    if (st == 1) return "R3";
    return "R2";
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  task automatic model_edge(bit in);
    bit realign;
    m_ps = m_s2;
    m_s2 = m_s1;
    m_s1 = in;
    realign = (m_state == 1) && m_ps;
    m_clk = realign ? 1'b0 : ~m_clk;
    case (m_state)
      0: if (m_ps) m_low = 0;
         else if (m_low == 7) begin m_state = 1; m_low = 0; end
         else m_low++;
      1: if (m_ps) begin m_state = 2; m_seq = 0; end
      default: if (m_seq == 19) m_state = 0; else m_seq++;
    endcase
  endtask

  task automatic step(bit in);
    int prev_state;
    ext_rst_n = in;
    @(posedge osc_clk);
    prev_state = m_state;
    model_edge(in);
    @(negedge osc_clk);
    cycles++;
    chk((prev_state == 1 && m_state == 2) ? "R4" : "R1", "state_clk", state_clk, m_clk);
    chk(tag_core(m_state, m_ps), "core_rst_n", core_rst_n, m_state == 0);
    chk("R6", "rst_pull_low", rst_pull_low, m_state != 0);
  endtask

  initial begin
    int n;
    while (cycles < 200000) begin
      @(posedge osc_clk);
      n = cycles;
    end
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=<200000", n);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed_dummy;
    int rel;
    seed_dummy = $urandom(32'h5eed_0c1d);
    @(negedge osc_clk);
    @(negedge osc_clk);
    // Power-on state (R3, R6)
    chk("R3", "core_rst_n after power-on", core_rst_n, 0);
    chk("R6", "rst_pull_low after power-on", rst_pull_low, 1);
    chk("R1", "state_clk after power-on", state_clk, 0);
    por_n = 1'b1;
    for (int i = 0; i < 5; i++) step(1'b0);

    // Directed: release latency R8 + sequence length R5
    rel = 0;
    for (int i = 0; i < 40; i++) begin
      step(1'b1);
      if (core_rst_n && rel == 0) rel = i + 1;
    end
    chk("R8", "edges from request high to core release", rel, 23);

    // Directed: low pulse of 7 cycles ignored (R2)
    for (int i = 0; i < 7; i++) step(1'b0);
    for (int i = 0; i < 4; i++) step(1'b1);
    chk("R2", "core_rst_n after 7-cycle dip", core_rst_n, 1);

    // Directed: exactly 8 cycles accepted (R3)
    for (int i = 0; i < 8; i++) step(1'b0);
    step(1'b1);
    step(1'b1);
    chk("R3", "core_rst_n after 8-cycle low", core_rst_n, 0);

    // Directed: new low during sequence is ignored (R7, R4)
    for (int i = 0; i < 4; i++) step(1'b1);
    for (int i = 0; i < 10; i++) step(1'b0);
    rel = 0;
    for (int i = 0; i < 30; i++) begin
      step(1'b1);
      if (core_rst_n && rel == 0) rel = i + 1;
    end
    chk("R7", "release edge with low inside sequence", rel, 7);

    // Constrained random pulses
    for (int k = 0; k < 300; k++) begin
      int lo, hi;
      lo = 1 + int'($urandom_range(23, 0));
      hi = 1 + int'($urandom_range(39, 0));
      for (int i = 0; i < lo; i++) step(1'b0);
      for (int i = 0; i < hi; i++) step(1'b1);
    end
    for (int i = 0; i < 30; i++) step(1'b1);
    chk("R5", "core_rst_n settled high", core_rst_n, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule